// File: doc/BRIEF.md
# Bitfield Extract Unit

This datapath unit pulls a contiguous field out of a 32-bit source word and returns it right-aligned in a 32-bit result. The caller names the field by the position of its lowest bit and by its width. A select input picks how the bits above the field are filled. In signed mode they repeat the field's top bit. In unsigned mode they are cleared to zero.

One request is accepted per clock, marked by a valid strobe. The result appears one clock later on a registered output, together with a result-valid strobe. If the position and width together describe a field that runs past bit 31, or if the width is zero, the unit raises an illegal-parameter flag with that result and forces the result word to zero. The unit has no condition or status flag outputs.

Top module: `bfx_unit`

## Requirements
- R1: For a legal request, result bits width-1 down to 0 equal source bits lsb+width-1 down to lsb. The lsb input is 5 bits wide and names the lowest field bit, from 0 to 31.
- R2: The width input is 6 bits wide. A request is legal only when width is at least 1 and lsb+width is at most 32. Any other request sets out_illegal.
- R3: With sign_sel = 1, every result bit above the field equals source bit lsb+width-1. Example: lsb 20 and width 4 give result[3:0] = src[23:20] and result[31:4] = src[23].
- R4: With sign_sel = 0, every result bit above the field is 0. Example: lsb 9 and width 10 give result[9:0] = src[18:9] and result[31:10] = 0.
- R5: For an illegal request, out_illegal is 1 in the same cycle as out_valid, and out_result is all zeros.
- R6: With lsb 0 and width 32, the result equals the source word unchanged, in both modes.
- R7: out_valid is 1 exactly one clock after a cycle in which in_valid is 1. In a cycle after in_valid is 0, out_valid is 0, out_illegal is 0, and out_result keeps its previous value.
- R8: While rst_n is low at a rising clock edge, the unit clears out_valid, out_result and out_illegal, whatever the other inputs are. The reset is synchronous and active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| src_word | input | 32 | Word the field is taken from |
| fld_lsb | input | 5 | Lowest bit position of the field |
| fld_width | input | 6 | Field width in bits (1 to 32 legal) |
| sign_sel | input | 1 | 1 = fill with the field's top bit, 0 = fill with zeros |
| out_valid | output | 1 | Result strobe, one clock after in_valid |
| out_result | output | 32 | Registered, right-aligned and extended field |
| out_illegal | output | 1 | Position and width were out of range |

## Verification
Two functions can meet in one capture edge: the out-of-range detection, which forces the result to zero and raises the flag, and the extraction of a legal field that has just been captured. The bench provokes this with back-to-back requests that alternate, such as a legal extraction followed at once by a zero-width or overlong request, and then a legal one again. It also places illegal requests at the edge of the range, for example lsb 4 with width 29, next to legal ones at the limit, such as lsb 31 with width 1 and lsb 0 with width 32. A scoreboard predicts each result and flag from the requirements and checks that a forced zero never leaks into the next legal result, and that a legal result never comes with a stale flag.

// File: rtl/bfx_pkg.sv
// Package bfx_pkg
// Shared sizing for the bitfield extract unit. Assumes the datapath width
// is a power of two, so that a position needs exactly clog2 bits and a width
// needs one bit more (it must be able to hold the full datapath width).
package bfx_pkg;
    parameter int DATA_W = 32;
    localparam int LSB_W = $clog2(DATA_W);
    localparam int WID_W = LSB_W + 1;
endpackage

// File: rtl/bfx_legal_chk.sv
// Module bfx_legal_chk
// Decides whether a position/width pair names a field that fits inside the
// datapath. Assumes the position is always within range (its width is
// clog2 of the datapath), so only a zero width or an overrun is illegal.
module bfx_legal_chk #(
    parameter int DATA_W = bfx_pkg::DATA_W,
    parameter int LSB_W  = $clog2(DATA_W),
    parameter int WID_W  = LSB_W + 1
) (
    input  logic [LSB_W-1:0] pos,
    input  logic [WID_W-1:0] len,
    output logic             fits
);
    localparam int SUM_W = WID_W + 1;

    logic [SUM_W-1:0] span_end;

    // Purpose: form one past the top field bit, then compare it to the word size.
    always_comb begin
        span_end = SUM_W'(pos) + SUM_W'(len);
        fits     = (len != '0) && (span_end <= SUM_W'(DATA_W));
    end
endmodule

// File: rtl/bfx_field_align.sv
// Module bfx_field_align
// Shifts the source right so that the field starts at bit 0. It builds a
// mask of the field's bit positions and picks out the field's top bit.
// Assumes len is at most DATA_W when the caller uses the top bit. For other
// values the top bit reads as zero, and the caller discards the result.
module bfx_field_align #(
    parameter int DATA_W = bfx_pkg::DATA_W,
    parameter int LSB_W  = $clog2(DATA_W),
    parameter int WID_W  = LSB_W + 1
) (
    input  logic [DATA_W-1:0] src,
    input  logic [LSB_W-1:0]  pos,
    input  logic [WID_W-1:0]  len,
    output logic [DATA_W-1:0] aligned,
    output logic [DATA_W-1:0] fmask,
    output logic              top_bit
);
    // Purpose: move the field down to bit 0.
    always_comb begin
        aligned = src >> pos;
    end

    // One comparator per bit: the bit belongs to the field when its index is below len.
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_mask
        assign fmask[gi] = (WID_W'(gi) < len);
    end

    // Purpose: select the field's most significant bit after alignment.
    always_comb begin
        top_bit = 1'b0;
        if ((len != '0) && (len <= WID_W'(DATA_W))) begin
            top_bit = aligned[LSB_W'(len - WID_W'(1))];
        end
    end
endmodule

// File: rtl/bfx_extend.sv
// Module bfx_extend
// Keeps the bits of an aligned value that lie inside the field mask and
// fills every other bit with the fill value. The fill value is the field's
// top bit in signed mode and zero otherwise. Assumes the mask is contiguous
// from bit 0.
module bfx_extend #(
    parameter int DATA_W = bfx_pkg::DATA_W
) (
    input  logic [DATA_W-1:0] aligned,
    input  logic [DATA_W-1:0] fmask,
    input  logic              top_bit,
    input  logic              sign_en,
    output logic [DATA_W-1:0] ext
);
    logic fill;

    // Purpose: choose the value used for the bits above the field.
    always_comb begin
        fill = sign_en & top_bit;
    end

    // Per-bit select between field data and the fill value.
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_ext
        assign ext[gi] = fmask[gi] ? aligned[gi] : fill;
    end
endmodule

// File: rtl/bfx_unit.sv
// Module bfx_unit (top)
// Bitfield extract with sign or zero fill and a one-cycle registered output.
// An out-of-range request yields a zero result with the illegal flag set.
// Assumes one request per cycle with no back-pressure. The reset is
// synchronous and active low.
module bfx_unit #(
    parameter int DATA_W = bfx_pkg::DATA_W,
    parameter int LSB_W  = $clog2(DATA_W),
    parameter int WID_W  = LSB_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] src_word,
    input  logic [LSB_W-1:0]  fld_lsb,
    input  logic [WID_W-1:0]  fld_width,
    input  logic              sign_sel,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_illegal
);
    logic              req_legal;
    logic [DATA_W-1:0] aligned_w;
    logic [DATA_W-1:0] fmask_w;
    logic              top_w;
    logic [DATA_W-1:0] ext_w;
    logic [DATA_W-1:0] next_result;

    bfx_legal_chk #(.DATA_W(DATA_W), .LSB_W(LSB_W), .WID_W(WID_W)) legal_i (
        .pos  (fld_lsb),
        .len  (fld_width),
        .fits (req_legal)
    );

    bfx_field_align #(.DATA_W(DATA_W), .LSB_W(LSB_W), .WID_W(WID_W)) align_i (
        .src     (src_word),
        .pos     (fld_lsb),
        .len     (fld_width),
        .aligned (aligned_w),
        .fmask   (fmask_w),
        .top_bit (top_w)
    );

    bfx_extend #(.DATA_W(DATA_W)) ext_i (
        .aligned (aligned_w),
        .fmask   (fmask_w),
        .top_bit (top_w),
        .sign_en (sign_sel),
        .ext     (ext_w)
    );

    // Purpose: force the result to zero when the field does not fit.
    always_comb begin
        next_result = req_legal ? ext_w : '0;
    end

    // Purpose: output register stage, with a synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_result  <= '0;
            out_illegal <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result  <= next_result;
                out_illegal <= ~req_legal;
            end else begin
                out_illegal <= 1'b0;
            end
        end
    end

    // R7: one-cycle latency, and the result holds while idle.
    a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_illegal && $stable(out_result)));

    // R5: a raised flag always comes with a valid, all-zero result.
    a_r5_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (out_valid && out_result == '0));

    // R2: a zero width, or a width larger than the room left above lsb, raises the flag.
    a_r2_range_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (fld_width == '0 ||
            fld_width > (WID_W'(DATA_W) - WID_W'(fld_lsb)))) |=> out_illegal);

    // R4: in zero-fill mode no bit outside the field mask is set.
    a_r4_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !sign_sel && req_legal) |-> ((ext_w & ~fmask_w) == '0));

    // R3: in sign-fill mode, a set top bit makes every bit outside the mask one.
    a_r3_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sign_sel && req_legal && top_w) |-> ((ext_w | fmask_w) == '1));
endmodule

// File: tb/bfx_unit_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes predicted results into a queue, and a
// monitor on the falling edge pops and compares them as results appear.
module bfx_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] src_word = '0;
    logic [4:0]  fld_lsb = '0;
    logic [5:0]  fld_width = '0;
    logic        sign_sel = 1'b0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_illegal;

    typedef struct {
        logic [31:0] res;
        logic        ill;
        string       req;
    } exp_t;

    exp_t        sb_q[$];
    int          checks = 0;
    int          fails = 0;
    logic        mon_en = 1'b0;
    logic [31:0] last_res = '0;
    logic        finished = 1'b0;

    always #2.5 clk = ~clk;

    bfx_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_word(src_word),
        .fld_lsb(fld_lsb), .fld_width(fld_width), .sign_sel(sign_sel),
        .out_valid(out_valid), .out_result(out_result), .out_illegal(out_illegal)
    );

    function automatic exp_t predict(logic [31:0] s, int lsb, int w, logic sg, string tag);
        exp_t e;
        e.req = tag;
        e.res = '0;
        e.ill = 1'b0;
        if (w == 0 || lsb + w > 32) begin
            e.ill = 1'b1;
        end else begin
            for (int i = 0; i < 32; i++) begin
                if (i < w) e.res[i] = s[lsb + i];
                else       e.res[i] = sg ? s[lsb + w - 1] : 1'b0;
            end
        end
        return e;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic op(logic [31:0] s, int lsb, int w, logic sg, string tag);
        @(posedge clk);
        #1;
        in_valid  = 1'b1;
        src_word  = s;
        fld_lsb   = 5'(lsb);
        fld_width = 6'(w);
        sign_sel  = sg;
        sb_q.push_back(predict(s, lsb, w, sg, tag));
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
            in_valid = 1'b0;
            src_word = $urandom;
        end
    endtask

    // Monitor: compare each result with the head of the queue, and check holds while idle.
    always @(negedge clk) begin
        if (mon_en && rst_n) begin
            if (out_valid) begin
                if (sb_q.size() == 0) begin
                    check("R7 unexpected valid", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check({e.req, " result"}, out_result, e.res);
                    check({e.req, " illegal flag"}, {31'd0, out_illegal}, {31'd0, e.ill});
                    last_res = out_result;
                end
            end else begin
                check("R7 idle hold", out_result, last_res);
                check("R7 idle flag", {31'd0, out_illegal}, 32'd0);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R8: requests presented during reset must not reach the outputs.
        in_valid = 1'b1; src_word = 32'hFFFF_FFFF; fld_lsb = 5'd0; fld_width = 6'd0; sign_sel = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 reset valid", {31'd0, out_valid}, 32'd0);
        check("R8 reset result", out_result, 32'd0);
        check("R8 reset illegal", {31'd0, out_illegal}, 32'd0);
        #1;
        in_valid = 1'b0;
        rst_n = 1'b1;
        mon_en = 1'b1;

        op(32'h00F0_0000, 20, 4, 1'b1, "R3 example negative");
        op(32'h0070_0000, 20, 4, 1'b1, "R3 example positive");
        op(32'hFFFF_FFFF, 9, 10, 1'b0, "R4 example ones");
        op(32'h1234_5678, 9, 10, 1'b0, "R4 example mixed");
        op(32'h8000_0001, 0, 32, 1'b1, "R6 whole word signed");
        op(32'h8000_0001, 0, 32, 1'b0, "R6 whole word unsigned");
        op(32'h8000_0000, 31, 1, 1'b1, "R3 top bit field");
        op(32'h8000_0000, 31, 1, 1'b0, "R4 top bit field");
        op(32'hDEAD_BEEF, 3, 0, 1'b1, "R5 zero width after legal");
        op(32'hDEAD_BEEF, 3, 12, 1'b1, "R1 legal after illegal");
        op(32'hFFFF_FFFF, 4, 29, 1'b1, "R2 overrun by one");
        op(32'hFFFF_FFFF, 4, 28, 1'b1, "R2 fits exactly");
        op(32'hFFFF_FFFF, 0, 63, 1'b0, "R2 width 63");
        op(32'hFFFF_FFFF, 31, 2, 1'b0, "R5 overrun at lsb 31");
        idle(3);
        op(32'hA5A5_A5A5, 7, 9, 1'b1, "R1 after idle gap");
        idle(1);
        for (int n = 0; n < 400; n++) begin
            int w;
            w = (n % 7 == 0) ? int'($urandom_range(0, 40)) : int'($urandom_range(1, 32));
            op($urandom, int'($urandom_range(0, 31)), w, 1'($urandom),
               "R1 random pattern");
            if (n % 5 == 0) idle(int'($urandom_range(1, 3)));
        end
        idle(4);
        check("R7 queue drained", 32'(sb_q.size()), 32'd0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule